// File: doc/BRIEF.md
# Dual-Channel Disk Interface Interrupt and Register Decoder

This block is the slave-side register decoder of a two-channel disk interface expansion card. A host reaches it through a byte-wide memory-mapped bus with separate read and write strobes. It keeps one interrupt enable per drive channel and merges the two enabled drive interrupt lines into a single host interrupt. It also holds a small control byte that routes the DMA handshake to one channel and opens the extended address window. It returns a fixed 4-bit board identity code, one bit per location.

Each channel's enable is set by any write to that channel's mask location and cleared when the same location is read. Software routes interrupts to one channel by writing that channel's mask location and then reading the other channel's. Accesses that land in a channel's taskfile window or alternate status location are turned into a per-channel chip-select and a 3-bit register index for an external drive-bus model. This happens only while the extended window is open.

Top module: `dchan_irq_hub`

## Requirements
- R1: After reset both channel enables are 0, the control byte is 0, and host_irq, dma_route and ext_win_en are 0.
- R2: A write of any data to offset 0x2200 (channel 0) or 0x3200 (channel 1) sets that channel's enable. A read of the same offset returns the current enable in bit 0 and clears it on that cycle. When a read and a write hit the location together, the write wins and the enable ends up set.
- R3: host_irq is high exactly when some channel has both its enable and its drv_irq input high.
- R4: A read of offset 0x2290 (channel 0) or 0x3290 (channel 1) returns that channel's drv_irq level in bit 0 with bits 7:1 zero, and changes no enable.
- R5: A read of offset 0x2280 + 4*k (k = 0..3) returns bit k of the board code in bit 0. The default board code is 3, so the values read are 1, 1, 0, 0 for k = 0..3.
- R6: The control byte at offset 0 can be written and read back. Bit 0 drives dma_route (0 selects channel 0, 1 selects channel 1) and bit 5 drives ext_win_en. Writing 0 makes both outputs low.
- R7: While ext_win_en is high, an access strobe at offset base + (n << 6), with n = 0..7 and base 0x2000 for channel 0 or 0x3000 for channel 1, raises only tf_cs[channel] and drives tf_reg = n.
- R8: While ext_win_en is high, an access strobe at offset 0x2380 raises only alt_cs[0], and one at 0x3380 raises only alt_cs[1].
- R9: While ext_win_en is low, tf_cs and alt_cs stay 0 for every access.
- R10: Writing one channel's mask location and then reading the other channel's leaves exactly the written channel enabled, for either channel.
- R11: A read of an offset that maps to no register returns 0 and changes no enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 14 | Byte offset of the access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address (combinational) |
| drv_irq | input | 2 | Raw interrupt request of each drive channel |
| host_irq | output | 1 | Combined enabled interrupt to the host |
| dma_route | output | 1 | Channel that receives the DMA handshake |
| ext_win_en | output | 1 | Extended address window open |
| tf_cs | output | 2 | Per-channel taskfile register select |
| tf_reg | output | 3 | Taskfile register index |
| alt_cs | output | 2 | Per-channel alternate status/control select |

## Verification
The bench builds the block with its default geometry: a 14-bit offset, a 64-byte register step, eight taskfile registers per channel, and board code 3. With that geometry every taskfile index of both windows is reachable. The code value 3 gives identity bits with both ones and zeros, so a bit-order fault in the identity decode becomes visible. These values also place the mask, status and alternate locations on a non-trivial offset pattern, so a wrong channel or register in the decode shows up as a wrong select or a wrong read value.

// File: rtl/dchan_pkg.sv
package dchan_pkg;

  localparam int NCH = 2;
  localparam int IDW = 4;

  localparam logic [31:0] CTRL_OFS = 32'h0000_0000;
  localparam logic [31:0] ID_BASE  = 32'h0000_2280;
  localparam int          ID_STEP  = 4;

  localparam int DMA_BIT = 0;
  localparam int EXT_BIT = 5;

  function automatic logic [31:0] tf_base(int ch);
    return (ch != 0) ? 32'h0000_3000 : 32'h0000_2000;
  endfunction

  function automatic logic [31:0] mask_ofs(int ch);
    return (ch != 0) ? 32'h0000_3200 : 32'h0000_2200;
  endfunction

  function automatic logic [31:0] stat_ofs(int ch);
    return (ch != 0) ? 32'h0000_3290 : 32'h0000_2290;
  endfunction

  function automatic logic [31:0] alt_ofs(int ch);
    return (ch != 0) ? 32'h0000_3380 : 32'h0000_2380;
  endfunction

  typedef struct packed {
    logic           ctrl;
    logic [NCH-1:0] mask;
    logic [NCH-1:0] stat;
    logic [NCH-1:0] tf;
    logic [NCH-1:0] alt;
    logic [IDW-1:0] ident;
  } hit_t;

endpackage

// File: rtl/dchan_decode.sv
module dchan_decode
  import dchan_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int STEP   = 6,
  parameter int NREG   = 8,
  parameter int IDX_W  = $clog2(NREG)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output hit_t              hit_o,
  output logic [IDX_W-1:0]  idx_o
);

  localparam logic [31:0] WIN_SPAN = 32'(NREG) << STEP;

  logic [31:0]    a32;
  logic [NCH-1:0] mask_h, stat_h, tf_h, alt_h;
  logic [IDW-1:0] id_h;
  logic [IDX_W-1:0] idx_ch [NCH];

  assign a32 = 32'(addr_i);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [31:0] off;
    assign off         = a32 - tf_base(ch);
    assign tf_h[ch]    = (a32 >= tf_base(ch)) && (off < WIN_SPAN) &&
                         (off[STEP-1:0] == '0);
    assign idx_ch[ch]  = off[STEP +: IDX_W];
    assign mask_h[ch]  = (a32 == mask_ofs(ch));
    assign stat_h[ch]  = (a32 == stat_ofs(ch));
    assign alt_h[ch]   = (a32 == alt_ofs(ch));
  end

  for (genvar k = 0; k < IDW; k++) begin : g_id
    assign id_h[k] = (a32 == ID_BASE + 32'(ID_STEP * k));
  end

  always_comb begin
    hit_o.ctrl  = (a32 == CTRL_OFS);
    hit_o.mask  = mask_h;
    hit_o.stat  = stat_h;
    hit_o.tf    = tf_h;
    hit_o.alt   = alt_h;
    hit_o.ident = id_h;
  end

  always_comb begin
    idx_o = idx_ch[0];
    for (int ch = 1; ch < NCH; ch++) begin
      if (tf_h[ch]) idx_o = idx_ch[ch];
    end
  end

endmodule

// File: rtl/dchan_chan.sv
module dchan_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic raw_i,
  output logic en_o,
  output logic req_o
);

  logic en_q, en_d;

  always_comb begin
    en_d = en_q;
    if (set_i)      en_d = 1'b1;
    else if (clr_i) en_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              en_q <= 1'b0;
    else if (set_i || clr_i) en_q <= en_d;
  end

  assign en_o  = en_q;
  assign req_o = en_q & raw_i;

  AST_WRITE_SETS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> en_o); // R2
  AST_READ_CLEARS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !en_o); // R2
  AST_EN_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(en_o)); // R11

endmodule

// File: rtl/dchan_ctrl.sv
module dchan_ctrl
  import dchan_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] q_o,
  output logic       route_o,
  output logic       ext_o
);

  logic [7:0] q_r, q_d;

  always_comb begin
    q_d = q_r;
    if (we_i) q_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_r <= '0;
    else if (we_i) q_r <= q_d;
  end

  assign q_o     = q_r;
  assign route_o = q_r[DMA_BIT];
  assign ext_o   = q_r[EXT_BIT];

  AST_ZERO_CLOSES_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && wdata_i == 8'h00) |=> (!route_o && !ext_o)); // R6

endmodule

// File: rtl/dchan_irq_hub.sv
module dchan_irq_hub
  import dchan_pkg::*;
#(
  parameter int             ADDR_W   = 14,
  parameter int             STEP     = 6,
  parameter int             NREG     = 8,
  parameter logic [IDW-1:0] BOARD_ID = 4'd3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [1:0]        drv_irq,
  output logic              host_irq,
  output logic              dma_route,
  output logic              ext_win_en,
  output logic [1:0]        tf_cs,
  output logic [2:0]        tf_reg,
  output logic [1:0]        alt_cs
);

  localparam int IDX_W = $clog2(NREG);

  logic [1:0] rs_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  hit_t             hit;
  logic [IDX_W-1:0] idx;

  dchan_decode #(.ADDR_W(ADDR_W), .STEP(STEP), .NREG(NREG)) u_dec (
    .addr_i (bus_addr),
    .hit_o  (hit),
    .idx_o  (idx)
  );

  logic [7:0] ctrl_q;

  dchan_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .we_i    (bus_wr & hit.ctrl),
    .wdata_i (bus_wdata),
    .q_o     (ctrl_q),
    .route_o (dma_route),
    .ext_o   (ext_win_en)
  );

  logic [NCH-1:0] en_vec, req_vec;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    dchan_chan u_chan (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .set_i (bus_wr & hit.mask[ch]),
      .clr_i (bus_rd & hit.mask[ch]),
      .raw_i (drv_irq[ch]),
      .en_o  (en_vec[ch]),
      .req_o (req_vec[ch])
    );
  end

  assign host_irq = |req_vec;

  always_comb begin
    bus_rdata = '0;
    if (hit.ctrl) bus_rdata = ctrl_q;
    for (int ch = 0; ch < NCH; ch++) begin
      if (hit.mask[ch]) bus_rdata[0] = en_vec[ch];
      if (hit.stat[ch]) bus_rdata[0] = drv_irq[ch];
    end
    for (int k = 0; k < IDW; k++) begin
      if (hit.ident[k]) bus_rdata[0] = BOARD_ID[k];
    end
  end

  logic acc_open;
  assign acc_open = (bus_rd | bus_wr) & ext_win_en;

  assign tf_cs  = hit.tf  & {NCH{acc_open}};
  assign alt_cs = hit.alt & {NCH{acc_open}};
  assign tf_reg = 3'(idx);

  AST_QUIET_WHEN_MASKED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (en_vec == '0) |-> !host_irq); // R3
  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({tf_cs, alt_cs})); // R7
  AST_WINDOW_CLOSED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ext_win_en |-> (tf_cs == '0 && alt_cs == '0)); // R9

endmodule

// File: tb/tb_dchan_irq_hub.sv
module tb_dchan_irq_hub;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [1:0]  drv_irq = '0;
  logic        host_irq, dma_route, ext_win_en;
  logic [1:0]  tf_cs, alt_cs;
  logic [2:0]  tf_reg;

  int vectors = 0;
  int fails   = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  dchan_irq_hub dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .drv_irq(drv_irq), .host_irq(host_irq), .dma_route(dma_route),
    .ext_win_en(ext_win_en), .tf_cs(tf_cs), .tf_reg(tf_reg), .alt_cs(alt_cs)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  task automatic bus_write(logic [13:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [13:0] a, logic [7:0] exp, string req);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(req);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic bus_rdwr(logic [13:0] a, logic [7:0] exp, string req);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1; bus_wr = 1'b1; bus_wdata = 8'h00;
    exp_q.push_back(exp); tag_q.push_back(req);
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic probe_sel(logic [13:0] a, logic [1:0] exp_tf, logic [2:0] exp_reg,
                           logic [1:0] exp_alt, string req);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1;
    #2;
    check(req, {6'b0, tf_cs}, {6'b0, exp_tf});
    if (exp_tf != 2'b00) check(req, {5'b0, tf_reg}, {5'b0, exp_reg});
    check(req, {6'b0, alt_cs}, {6'b0, exp_alt});
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // scoreboard monitor: compares read data against queued expectations
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (bus_rd === 1'b1 && exp_q.size() > 0) begin
        logic [7:0] e;
        string      t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, bus_rdata, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 host_irq", {7'b0, host_irq}, 8'h00);
    check("R1 dma_route", {7'b0, dma_route}, 8'h00);
    check("R1 ext_win_en", {7'b0, ext_win_en}, 8'h00);
    bus_read(14'h0000, 8'h00, "R1 ctrl");
    bus_read(14'h2200, 8'h00, "R1 en0");

    // R3 / R4 raw level, masked
    drv_irq = 2'b11;
    @(negedge clk);
    check("R3 masked", {7'b0, host_irq}, 8'h00);
    bus_read(14'h2290, 8'h01, "R4 stat0");
    bus_read(14'h3290, 8'h01, "R4 stat1");
    drv_irq = 2'b00;
    bus_read(14'h3290, 8'h00, "R4 stat1 low");

    // R2 set and read-clear
    drv_irq = 2'b01;
    bus_write(14'h2200, 8'h5A);
    check("R2 R3 set0", {7'b0, host_irq}, 8'h01);
    bus_read(14'h2200, 8'h01, "R2 read en0");
    bus_read(14'h2200, 8'h00, "R2 cleared en0");
    check("R2 R3 cleared", {7'b0, host_irq}, 8'h00);

    // R10 routing to channel 0
    bus_write(14'h2200, 8'h00);
    bus_read(14'h3200, 8'h00, "R10 ch1 off");
    drv_irq = 2'b10;
    @(negedge clk);
    check("R10 ch0 route ch1 raw", {7'b0, host_irq}, 8'h00);
    drv_irq = 2'b01;
    @(negedge clk);
    check("R10 ch0 route ch0 raw", {7'b0, host_irq}, 8'h01);

    // R10 routing to channel 1
    bus_write(14'h3200, 8'hFF);
    bus_read(14'h2200, 8'h01, "R10 ch0 was on");
    check("R10 ch1 route ch0 raw", {7'b0, host_irq}, 8'h00);
    drv_irq = 2'b10;
    @(negedge clk);
    check("R10 ch1 route ch1 raw", {7'b0, host_irq}, 8'h01);

    // R4 / R11 no side effects
    bus_read(14'h3290, 8'h01, "R4 stat1 read");
    bus_read(14'h1234, 8'h00, "R11 unmapped");
    bus_read(14'h3200, 8'h01, "R11 en1 kept");
    check("R2 en1 cleared", {7'b0, host_irq}, 8'h00);

    // R2 read and write together: write wins
    bus_rdwr(14'h2200, 8'h00, "R2 rdwr old");
    bus_read(14'h2200, 8'h01, "R2 rdwr result");

    // R5 identity, code 3
    bus_read(14'h2280, 8'h01, "R5 id0");
    bus_read(14'h2284, 8'h01, "R5 id1");
    bus_read(14'h2288, 8'h00, "R5 id2");
    bus_read(14'h228C, 8'h00, "R5 id3");

    // R9 window closed
    probe_sel(14'h2040, 2'b00, 3'd0, 2'b00, "R9 closed tf");
    probe_sel(14'h3380, 2'b00, 3'd0, 2'b00, "R9 closed alt");

    // R6 control
    bus_write(14'h0000, 8'h21);
    check("R6 route", {7'b0, dma_route}, 8'h01);
    check("R6 ext", {7'b0, ext_win_en}, 8'h01);
    bus_read(14'h0000, 8'h21, "R6 readback");

    // R7 taskfile windows
    for (int ch = 0; ch < 2; ch++) begin
      for (int n = 0; n < 8; n++) begin
        logic [13:0] a;
        a = (ch != 0 ? 14'h3000 : 14'h2000) + 14'(n << 6);
        probe_sel(a, (ch != 0) ? 2'b10 : 2'b01, 3'(n), 2'b00, "R7 tf");
      end
    end
    probe_sel(14'h2020, 2'b00, 3'd0, 2'b00, "R7 off-step");

    // R8 alternate status
    probe_sel(14'h2380, 2'b00, 3'd0, 2'b01, "R8 alt0");
    probe_sel(14'h3380, 2'b00, 3'd0, 2'b10, "R8 alt1");

    // R6 write 0 closes everything
    bus_write(14'h0000, 8'h00);
    check("R6 zero route", {7'b0, dma_route}, 8'h00);
    check("R6 zero ext", {7'b0, ext_win_en}, 8'h00);
    probe_sel(14'h3000, 2'b00, 3'd0, 2'b00, "R9 after zero");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    finish_run();
  end

endmodule